// File: doc/BRIEF.md
# Firmware-Hub Cycle Target

This block sits on the target side of a 4-bit LPC bus. It watches the host's frame strobe and the shared nibble lines, picks out firmware-hub style memory cycles that carry this device's ID, and serves single-byte reads and writes. A claimed cycle becomes one request on a plain byte-wide memory port that carries a full 32-bit address. The block stretches the bus cycle with wait codes until the internal side answers.

The LAD lines are split into an input nibble, an output nibble and an output enable, so that the pad ring can build the tri-state driver. The configuration byte is held steady by the surrounding logic. Its upper nibble is the ID this target answers to. All bus timing after the START and ID nibbles follows ordinary LPC memory cycles: eight address nibbles, host turnaround, target SYNC, data, and a closing turnaround.

Top module: `fwh_target`

## Requirements
- R1: While reset is asserted, lad_oe and mem_req are low.
- R2: A cycle starts when lframe_n is low and lad_in is 4'b1101 (read) or 4'b1110 (write). Any other nibble seen with lframe_n low leaves the block idle. It does not drive the bus or raise mem_req for that cycle. mem_we reports the direction of the claimed cycle.
- R3: The nibble after START is compared with cfg_byte[7:4]. On a mismatch the cycle is ignored: lad_oe and mem_req stay low.
- R4: The eight address nibbles arrive most significant first and form mem_addr. mem_addr stays stable while mem_req is high.
- R5: On a write, the two nibbles after the address form mem_wdata, low nibble first. Two host turnaround clocks follow.
- R6: On a read, the ready SYNC is followed by mem_rdata[3:0] and then mem_rdata[7:4] on lad_out.
- R7: SYNC clocks are counted from 1, the clock after the second host turnaround clock. Until the request is answered, SYNC clock j drives 4'b0101 (short wait) when j < LONG_AFTER, and 4'b0110 (long wait) otherwise. Once a long wait has been driven, short wait does not return. The clock after mem_rdy is sampled with mem_req high, SYNC drives 4'b0000 (ready).
- R8: After the last target nibble, the block drives 4'b1111 for one clock and then releases the bus. lad_oe is high only in SYNC, read-data and that one clock.
- R9: If lframe_n goes low mid-cycle with a nibble that is not a START code, the next clock has lad_oe and mem_req low. The block is idle and accepts a new cycle.
- R10: mem_req rises in the first host turnaround clock after the address (after the data on a write). It stays high until mem_rdy is sampled high and is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_byte | input | 8 | Configuration; bits 7:4 hold the device ID |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Nibble sampled from the bus lines |
| lad_out | output | 4 | Nibble to drive onto the bus lines |
| lad_oe | output | 1 | Enable for the bus line drivers |
| mem_req | output | 1 | Internal access request |
| mem_we | output | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Internal side answers the request |

## Verification
All sixteen ID nibbles are tried against one configured ID. This separates a claimed cycle from an ignored one. All sixteen START nibbles are tried too, which sets the two valid codes apart from the fourteen others. Read and write cycles are run with memory latencies from zero to seven clocks. Each latency gives a different mix of short and long wait codes, so the switch point to long waits and the ready code can be checked clock by clock. The address and data patterns are chosen so that nibble order faults show up. Aborts are placed in the address phase and in the wait phase, and a normal cycle follows each abort to show the block is idle again.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  localparam logic [3:0] START_RD   = 4'b1101;
  localparam logic [3:0] START_WR   = 4'b1110;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] NIB_HIGH   = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_WD0, ST_WD1, ST_HTA0, ST_HTA1,
    ST_SYNC, ST_RD0, ST_RD1, ST_TTA0, ST_TTA1
  } fwh_state_e;

  function automatic logic is_start(input logic [3:0] nib);
    return (nib == START_RD) || (nib == START_WR);
  endfunction

  // pend = clocks the request has been outstanding
  function automatic logic [3:0] sync_pick(input logic done,
                                           input int unsigned pend,
                                           input int unsigned long_after);
    if (done) return SYNC_READY;
    if (pend > long_after) return SYNC_LONG;
    return SYNC_SHORT;
  endfunction

endpackage

// File: rtl/fwh_wait_track.sv
module fwh_wait_track #(
  parameter int LONG_AFTER = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       req,
  input  logic       rdy,
  input  logic [7:0] rdata,
  output logic       done,
  output logic [7:0] rdata_q,
  output logic [3:0] sync_code
);
  localparam int CMAX = LONG_AFTER + 1;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      done    <= 1'b0;
      rdata_q <= '0;
    end else if (clear) begin
      pend <= '0;
      done <= 1'b0;
    end else begin
      if (req && (pend != CW'(CMAX))) pend <= pend + 1'b1;
      if (req && rdy) begin
        done    <= 1'b1;
        rdata_q <= rdata;
      end
    end
  end

  assign sync_code = fwh_pkg::sync_pick(done, 32'(pend), LONG_AFTER);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clear |=> done);

endmodule

// File: rtl/fwh_nib_shift.sv
module fwh_nib_shift #(
  parameter int ADDR_NIBS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   addr_en,
  input  logic                   lo_en,
  input  logic                   hi_en,
  input  logic [3:0]             nib,
  output logic [4*ADDR_NIBS-1:0] addr,
  output logic [7:0]             wdata,
  output logic                   last_addr
);
  localparam int AW   = 4 * ADDR_NIBS;
  localparam int CNTW = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;

  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      addr  <= '0;
      wdata <= '0;
    end else begin
      if (clear) cnt <= '0;
      else if (addr_en) cnt <= cnt + 1'b1;
      if (addr_en) addr <= {addr[AW-5:0], nib};
      if (lo_en) wdata[3:0] <= nib;
      if (hi_en) wdata[7:4] <= nib;
    end
  end

  assign last_addr = (cnt == CNTW'(ADDR_NIBS - 1));

endmodule

// File: rtl/fwh_target.sv
module fwh_target #(
  parameter int ADDR_NIBS  = 8,
  parameter int LONG_AFTER = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             cfg_byte,
  input  logic                   lframe_n,
  input  logic [3:0]             lad_in,
  output logic [3:0]             lad_out,
  output logic                   lad_oe,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [4*ADDR_NIBS-1:0] mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  input  logic                   mem_rdy
);
  import fwh_pkg::*;

  fwh_state_e st, nxt;
  logic       we_q;
  logic       start_seen, id_hit, last_addr, done;
  logic [7:0] rdata_q;
  logic [3:0] sync_code;
  logic       cfg_unused;

  assign cfg_unused = ^cfg_byte[3:0];
  assign start_seen = !lframe_n && is_start(lad_in);
  assign id_hit     = (lad_in == cfg_byte[7:4]);

  always_comb begin
    nxt = st;
    if (!lframe_n) begin
      nxt = start_seen ? ST_ID : ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: nxt = ST_IDLE;
        ST_ID:   nxt = id_hit ? ST_ADDR : ST_IDLE;
        ST_ADDR: nxt = last_addr ? (we_q ? ST_WD0 : ST_HTA0) : ST_ADDR;
        ST_WD0:  nxt = ST_WD1;
        ST_WD1:  nxt = ST_HTA0;
        ST_HTA0: nxt = ST_HTA1;
        ST_HTA1: nxt = ST_SYNC;
        ST_SYNC: nxt = done ? (we_q ? ST_TTA0 : ST_RD0) : ST_SYNC;
        ST_RD0:  nxt = ST_RD1;
        ST_RD1:  nxt = ST_TTA0;
        ST_TTA0: nxt = ST_TTA1;
        ST_TTA1: nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      we_q <= 1'b0;
    end else begin
      st <= nxt;
      if (start_seen) we_q <= (lad_in == START_WR);
    end
  end

  fwh_nib_shift #(.ADDR_NIBS(ADDR_NIBS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_seen),
    .addr_en   (lframe_n && st == ST_ADDR),
    .lo_en     (lframe_n && st == ST_WD0),
    .hi_en     (lframe_n && st == ST_WD1),
    .nib       (lad_in),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .last_addr (last_addr)
  );

  assign mem_req = ((st == ST_HTA0) || (st == ST_HTA1) || (st == ST_SYNC)) && !done;
  assign mem_we  = we_q;

  fwh_wait_track #(.LONG_AFTER(LONG_AFTER)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_seen),
    .req       (mem_req),
    .rdy       (mem_rdy),
    .rdata     (mem_rdata),
    .done      (done),
    .rdata_q   (rdata_q),
    .sync_code (sync_code)
  );

  always_comb begin
    lad_oe  = 1'b0;
    lad_out = NIB_HIGH;
    unique case (st)
      ST_SYNC: begin lad_oe = 1'b1; lad_out = sync_code;    end
      ST_RD0:  begin lad_oe = 1'b1; lad_out = rdata_q[3:0]; end
      ST_RD1:  begin lad_oe = 1'b1; lad_out = rdata_q[7:4]; end
      ST_TTA0: begin lad_oe = 1'b1; lad_out = NIB_HIGH;     end
      default: begin lad_oe = 1'b0; lad_out = NIB_HIGH;     end
    endcase
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy && lframe_n |=> mem_req);

  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rdy |=> !mem_req);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n && !is_start(lad_in) |=> !lad_oe && !mem_req);

  // R7
  long_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SYNC && lad_out == SYNC_LONG && lframe_n |=> lad_out != SYNC_SHORT);

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> $stable(mem_addr));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_TTA0 |=> !lad_oe);

endmodule

// File: tb/tb_fwh_target.sv
`timescale 1ns/1ps
module tb_fwh_target;
  localparam int LA = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_byte = 8'hA5;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe, mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int n_run = 0, n_fail = 0;
  int lat = 0, pend_b = 0;
  bit got = 0, cap_we = 0, finished = 0;
  logic [31:0] cap_addr;
  logic [7:0]  cap_wd;

  always #2 clk = ~clk;

  function automatic logic [7:0] rfun(input logic [31:0] a);
    return a[7:0] ^ a[31:24] ^ 8'h3C;
  endfunction
  assign mem_rdata = rfun(mem_addr);

  fwh_target #(.ADDR_NIBS(8), .LONG_AFTER(LA)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .lframe_n(lframe_n),
    .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy));

  // memory model: answers after lat outstanding clocks
  initial mem_rdy = 1'b0;
  always @(negedge clk) begin
    if (mem_req) begin
      if (pend_b == lat) begin
        mem_rdy = 1'b1; got = 1'b1;
        cap_addr = mem_addr; cap_we = mem_we; cap_wd = mem_wdata;
      end else mem_rdy = 1'b0;
      pend_b++;
    end else begin
      mem_rdy = 1'b0; pend_b = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input logic lf, input logic [3:0] d);
    @(negedge clk);
    lframe_n = lf; lad_in = d;
    #1;
  endtask

  task automatic quiet(input string rq);
    chk(!lad_oe && !mem_req, rq, {lad_oe, mem_req}, 0);
  endtask

  task automatic xfer(input bit we, input logic [3:0] idn, input logic [31:0] a,
                      input logic [7:0] wd, input int l, input bit claim);
    int rj;
    logic [3:0] ex;
    lat = l; got = 0;
    cyc(0, we ? 4'hE : 4'hD); quiet("R2");
    cyc(1, idn); quiet("R3");
    for (int k = 0; k < 8; k++) begin
      cyc(1, a[31-4*k -: 4]); quiet("R4");
    end
    if (we) begin
      cyc(1, wd[3:0]); quiet("R5");
      cyc(1, wd[7:4]); quiet("R5");
    end
    cyc(1, 4'hF);
    if (claim) chk(mem_req && !lad_oe, "R10", {lad_oe, mem_req}, 1);
    else quiet("R3");
    cyc(1, 4'hF); chk(!lad_oe, "R5", lad_oe, 0);
    if (!claim) begin
      for (int k = 0; k < 6; k++) begin
        cyc(1, 4'hF); quiet("R3");
      end
      return;
    end
    rj = (l <= 1) ? 1 : l;
    for (int j = 1; j <= rj; j++) begin
      cyc(1, 4'hF);
      ex = (j == rj) ? 4'h0 : ((j >= LA) ? 4'h6 : 4'h5);
      chk(lad_oe && lad_out == ex, "R7", {lad_oe, lad_out}, {1'b1, ex});
    end
    chk(!mem_req, "R10", mem_req, 0);
    chk(got, "R10", got, 1);
    chk(cap_addr == a, "R4", cap_addr, a);
    chk(cap_we == we, "R2", cap_we, we);
    if (we) chk(cap_wd == wd, "R5", cap_wd, wd);
    else begin
      cyc(1, 4'hF);
      chk(lad_oe && lad_out == rfun(a)[3:0], "R6", {lad_oe, lad_out}, {1'b1, rfun(a)[3:0]});
      cyc(1, 4'hF);
      chk(lad_oe && lad_out == rfun(a)[7:4], "R6", {lad_oe, lad_out}, {1'b1, rfun(a)[7:4]});
    end
    cyc(1, 4'hF); chk(lad_oe && lad_out == 4'hF, "R8", {lad_oe, lad_out}, 5'h1F);
    cyc(1, 4'hF); chk(!lad_oe, "R8", lad_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 quiet("R1");
    rst_n = 1'b1;
    cyc(1, 4'hF); quiet("R1");

    // ID sweep against configured ID 4'hA
    for (int i = 0; i < 16; i++)
      xfer(i[0], 4'(i), 32'hF0E1D2C3 ^ (32'h01010101 * i), 8'(i * 17 + 3), 2, i == 10);

    // latency sweep, both directions
    for (int l = 0; l < 8; l++)
      for (int w = 0; w < 2; w++)
        xfer(w[0], 4'hA, 32'h12345678 + 32'h11111111 * l + 32'(w), 8'hC5 ^ 8'(l << 4), l, 1'b1);

    // START code sweep: only 1101 and 1110 claim
    for (int s = 0; s < 16; s++) begin
      if (s == 13 || s == 14) continue;
      cyc(0, 4'(s)); quiet("R2");
      cyc(1, 4'hA); quiet("R2");
      for (int k = 0; k < 12; k++) begin
        cyc(1, 4'(k)); quiet("R2");
      end
    end

    // abort in address phase
    cyc(0, 4'hD); cyc(1, 4'hA); cyc(1, 4'h1); cyc(1, 4'h2);
    cyc(0, 4'h0);
    cyc(1, 4'hF); quiet("R9");
    xfer(1'b0, 4'hA, 32'h89ABCDEF, 8'h00, 1, 1'b1);

    // abort during wait syncs
    lat = 6;
    cyc(0, 4'hD); cyc(1, 4'hA);
    for (int k = 0; k < 8; k++) cyc(1, 4'(k));
    cyc(1, 4'hF); cyc(1, 4'hF);
    cyc(1, 4'hF); chk(lad_oe && lad_out == 4'h5, "R7", lad_out, 5);
    cyc(1, 4'hF);
    cyc(0, 4'h0);
    cyc(1, 4'hF); quiet("R9");
    cyc(1, 4'hF); quiet("R9");
    xfer(1'b1, 4'hA, 32'h0000FFFF, 8'h96, 4, 1'b1);

    // other configured ID
    cfg_byte = 8'h0F;
    xfer(1'b0, 4'h0, 32'hDEADBEEF, 8'h00, 3, 1'b1);
    xfer(1'b0, 4'hA, 32'hDEADBEEF, 8'h00, 3, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule